// File: doc/BRIEF.md
# Constant-Operand Adder

This block adds a fixed, elaboration-time constant to a variable operand of `WIDTH` bits. It is purely combinational and produces the `WIDTH`-bit sum together with the carry out of the top bit position. Because one operand is known before elaboration, the datapath is shaped by the constant's bit pattern rather than built as a general two-operand adder.

Every bit below the constant's lowest set bit is a plain wire from input to output. At that bit and above, each position holds a single two-input cell fed by the operand bit and the ripple carry. Where the constant bit is 0, the cell is an ordinary half-adder. Where the constant bit is 1, the cell is a modified half-adder that also adds one. The carry entering the lowest set bit is zero.

Setting the constant to 1 gives an incrementer, and setting it to all ones gives a decrementer modulo 2^WIDTH. A designer instantiates the block wherever a fixed offset is added to a bus, for example address stepping or bias correction.

Top module: `const_adder`

## Requirements
- R1: If the constant's lowest set bit is at position h, sum bits below h equal the corresponding input bits for every input value.
- R2: For every input x, the concatenation {carry_o, sum_o} equals x + ADDEND computed as a (WIDTH+1)-bit unsigned number.
- R3: With ADDEND equal to 0, sum_o equals x_i and carry_o is 0 for every input.
- R4: With ADDEND equal to 1, sum_o equals (x_i + 1) mod 2^WIDTH, and carry_o is 1 only when x_i is all ones.
- R5: With ADDEND all ones, sum_o equals (x_i - 1) mod 2^WIDTH, and carry_o is 1 for every input except zero.
- R6: carry_o is 1 exactly when x_i is at least 2^WIDTH - ADDEND, for any nonzero ADDEND.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_i | input | WIDTH | Variable operand |
| sum_o | output | WIDTH | Low WIDTH bits of x_i + ADDEND |
| carry_o | output | 1 | Carry out of the most significant position |

## Verification
The assertions assume only that `x_i` holds a settled, two-valued value whenever the combinational checks evaluate. They make no assumption about its range, because every pattern is legal. The bench changes the operand only on a falling clock edge and samples the outputs after the next rising edge. This leaves the ripple chain settled well before any check. Each configuration is swept over all 2^WIDTH operand values, so no input outside the legal set is ever applied.

// File: rtl/const_adder_pkg.sv
package const_adder_pkg;

  localparam int unsigned MAX_WIDTH = 64;

  // Index of the lowest set bit of v within the first w bits; w if none is set.
  function automatic int unsigned lowest_one(input logic [MAX_WIDTH-1:0] v,
                                             input int unsigned w);
    int unsigned idx;
    idx = w;
    for (int i = int'(w) - 1; i >= 0; i--) begin
      if (v[i]) idx = i;
    end
    return idx;
  endfunction

endpackage

// File: rtl/ha_cell.sv
module ha_cell (
  input  logic a_i,
  input  logic b_i,
  output logic s_o,
  output logic c_o
);

  assign s_o = a_i ^ b_i;
  assign c_o = a_i & b_i;

  // R2: a half-adder result is at most 2, so sum and carry are never both set
  always_comb begin
    p_ha_excl_r2: assert (!(s_o && c_o))
      else $error("half-adder produced 3 from two bits");
  end

endmodule

// File: rtl/mha_cell.sv
module mha_cell (
  input  logic a_i,
  input  logic b_i,
  output logic s_o,
  output logic c_o
);

  // a + b + 1 as a two-bit carry/sum pair
  assign s_o = ~(a_i ^ b_i);
  assign c_o = a_i | b_i;

  // R2: adding one forces a nonzero result
  always_comb begin
    p_mha_nonzero_r2: assert (s_o || c_o)
      else $error("modified half-adder produced zero");
  end

endmodule

// File: rtl/const_adder_chain.sv
module const_adder_chain
  import const_adder_pkg::*;
#(
  parameter int unsigned            WIDTH  = 8,
  parameter logic [WIDTH-1:0]       ADDEND = '0
) (
  input  logic [WIDTH-1:0] x_i,
  output logic [WIDTH-1:0] s_o,
  output logic             c_o
);

  localparam int unsigned LSB = lowest_one(MAX_WIDTH'(ADDEND), WIDTH);

  logic [WIDTH:0] carry;

  assign carry[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i < LSB) begin : g_wire
      // R1: trailing-zero positions are a bare wire, carry stays zero
      assign s_o[i]       = x_i[i];
      assign carry[i + 1] = carry[i];
    end else if (ADDEND[i]) begin : g_mha
      mha_cell u_cell (
        .a_i (x_i[i]),
        .b_i (carry[i]),
        .s_o (s_o[i]),
        .c_o (carry[i + 1])
      );
    end else begin : g_ha
      ha_cell u_cell (
        .a_i (x_i[i]),
        .b_i (carry[i]),
        .s_o (s_o[i]),
        .c_o (carry[i + 1])
      );
    end
  end

  assign c_o = carry[WIDTH];

endmodule

// File: rtl/const_adder.sv
module const_adder #(
  parameter int unsigned      WIDTH  = 8,
  parameter logic [WIDTH-1:0] ADDEND = 8'h05
) (
  input  logic [WIDTH-1:0] x_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o
);

  const_adder_chain #(
    .WIDTH  (WIDTH),
    .ADDEND (ADDEND)
  ) u_chain (
    .x_i (x_i),
    .s_o (sum_o),
    .c_o (carry_o)
  );

  // R2: the cell chain matches plain arithmetic
  always_comb begin
    p_sum_exact_r2: assert ({carry_o, sum_o} == ({1'b0, x_i} + {1'b0, ADDEND}))
      else $error("sum mismatch");
  end

  if (ADDEND == WIDTH'(1)) begin : g_inc_chk
    // R4: an incrementer carries out only from all ones
    always_comb begin
      p_inc_carry_r4: assert (carry_o == (&x_i))
        else $error("incrementer carry wrong");
    end
  end

  if (ADDEND == {WIDTH{1'b1}}) begin : g_dec_chk
    // R5: a decrementer carries out for every nonzero input
    always_comb begin
      p_dec_carry_r5: assert (carry_o == (|x_i))
        else $error("decrementer carry wrong");
    end
  end

endmodule

// File: tb/const_adder_tb.sv
`timescale 1ns/1ps
module const_adder_tb;

  localparam int unsigned W = 8;
  localparam logic [W-1:0] K_ZERO = 8'h00;
  localparam logic [W-1:0] K_ONE  = 8'h01;
  localparam logic [W-1:0] K_ALL  = 8'hFF;
  localparam logic [W-1:0] K_TZ   = 8'h28;
  localparam logic [W-1:0] K_MIX  = 8'hB5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [W-1:0] x;
  logic [W-1:0] s_zero, s_one, s_all, s_tz, s_mix;
  logic         c_zero, c_one, c_all, c_tz, c_mix;

  int checks = 0;
  int fails  = 0;

  const_adder #(.WIDTH(W), .ADDEND(K_ZERO)) u_dut   (.x_i(x), .sum_o(s_zero), .carry_o(c_zero));
  const_adder #(.WIDTH(W), .ADDEND(K_ONE))  u_dut_1 (.x_i(x), .sum_o(s_one),  .carry_o(c_one));
  const_adder #(.WIDTH(W), .ADDEND(K_ALL))  u_dut_2 (.x_i(x), .sum_o(s_all),  .carry_o(c_all));
  const_adder #(.WIDTH(W), .ADDEND(K_TZ))   u_dut_3 (.x_i(x), .sum_o(s_tz),   .carry_o(c_tz));
  const_adder #(.WIDTH(W), .ADDEND(K_MIX))  u_dut_4 (.x_i(x), .sum_o(s_mix),  .carry_o(c_mix));

  task automatic check(input string req, input int got, input int exp, input int xv);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s x=%0h actual=%0h expected=%0h", req, xv, got, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int v = 0; v < (1 << W); v++) begin
      @(negedge clk);
      x = W'(v);
      @(posedge clk);
      #1;
      // R3: zero constant passes input through, no carry
      check("R3 sum",   int'(s_zero), v, v);
      check("R3 carry", int'(c_zero), 0, v);
      // R4: incrementer
      check("R4 sum",   int'(s_one), (v + 1) % (1 << W), v);
      check("R4 carry", int'(c_one), (v == (1 << W) - 1) ? 1 : 0, v);
      // R5: decrementer
      check("R5 sum",   int'(s_all), (v + (1 << W) - 1) % (1 << W), v);
      check("R5 carry", int'(c_all), (v != 0) ? 1 : 0, v);
      // R1: trailing zeros of 0x28 leave bits 2..0 untouched
      check("R1 low bits", int'(s_tz[2:0]), v % 8, v);
      // R2: full-width arithmetic for two patterns
      check("R2 k=28", int'({c_tz, s_tz}),   v + int'(K_TZ),  v);
      check("R2 k=B5", int'({c_mix, s_mix}), v + int'(K_MIX), v);
      // R6: carry threshold
      check("R6 k=B5", int'(c_mix), (v >= (1 << W) - int'(K_MIX)) ? 1 : 0, v);
      check("R6 k=28", int'(c_tz),  (v >= (1 << W) - int'(K_TZ))  ? 1 : 0, v);
    end
    summary();
  end

endmodule